// File: doc/BRIEF.md
# Two-Channel Triggered Peripheral/RAM Transfer Engine

This block moves data between a fixed peripheral register and a stepping RAM pointer for two independent channels. Each transfer unit is one byte or one 16-bit word. A channel moves one unit each time its selected hardware trigger line pulses, or each time software sets the kick bit in its control register. Every unit is one read cycle on a single-master memory bus followed by one write cycle. Byte units drive a single byte lane, chosen by address bit 0. Word units drive both lanes at an even address.

Software configures a channel through a small register port. It writes the mode, RAM pointer, peripheral address and unit count, then sets the enable bit. A programmed count of N yields N+1 units. After the last unit the channel disables itself and pulses its completion interrupt for one cycle. If software clears the enable bit before the run ends, the run stops without an interrupt, and the count and RAM pointer keep the values they held at that point.

Top module: `dma2ch_engine`

## Requirements
- R1: Mode bit 1 selects the direction. 0 reads the peripheral address and writes the RAM pointer. 1 reads the RAM pointer and writes the peripheral address.
- R2: Mode bit 0 = 0 selects byte units. A byte access drives bus_be 2'b01 at an even address or 2'b10 at an odd address. The moved byte is taken from the read lane and placed on both halves of bus_wdata.
- R3: Mode bit 0 = 1 selects word units. Word accesses drive bus_be 2'b11, and bit 0 of both the RAM and the peripheral address is forced to 0 on the bus.
- R4: The peripheral address never changes during a run. After each unit the RAM pointer becomes its effective bus address plus 1 for byte units or plus 2 for word units.
- R5: A count of N gives exactly N+1 units. The count is decremented after each unit except the last. After the last unit the enable bit reads 0 and done_irq for that channel is high for exactly one cycle.
- R6: Writing 0 to the enable bit (bit 0 of control register, select 4) stops the channel at once. No further bus writes or done_irq pulses follow, and the count and RAM pointer keep their values.
- R7: Mode bits 5:2 choose which trig_in line starts a unit for that channel. Pulses on other lines have no effect.
- R8: Writing the control register with bits 1:0 = 2'b11 enables the channel and posts one start request.
- R9: A trigger is held as pending until its unit is granted, so a trigger that arrives while the bus serves another unit is not lost.
- R10: When both channels are pending in the same cycle, channel 0 is served first.
- R11: Writes to the RAM pointer (select 1), peripheral address (select 2) and count (select 3) are ignored while the channel is enabled. The mode register is select 0.
- R12: Each unit is one bus read cycle followed directly by one bus write cycle. bus_rd and bus_wr are never high together.
- R13: After reset, both channels are disabled, all registers read 0, and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel selected for register access |
| cfg_sel | input | 3 | Register select: 0 mode, 1 RAM pointer, 2 peripheral address, 3 count, 4 control |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (control reads {pending, enable}) |
| trig_in | input | NUM_SRC | Hardware trigger pulses |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Bus read strobe, data returned in the same cycle |
| bus_wr | output | 1 | Bus write strobe |
| bus_be | output | 2 | Byte lane enables |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| done_irq | output | NUM_CH | Per-channel completion pulse |

## Verification
The bound checker checks the bus discipline on every cycle: the two strobes are exclusive, every write directly follows a read, word accesses are even and byte accesses use the lane that matches address bit 0. It also checks that each completion pulse is a single cycle, follows a bus write and leaves the channel disabled. Some behaviours can only be shown by the bench scenarios: the exact data and addresses of whole runs in both directions, the N+1 unit count, the frozen count and pointer after a forced stop, ignored trigger lines and register writes, and the service order when both channels are pending.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

   localparam int TRIG_SEL_W = 4;

   localparam logic [2:0] SEL_MODE = 3'd0;
   localparam logic [2:0] SEL_RAM  = 3'd1;
   localparam logic [2:0] SEL_PER  = 3'd2;
   localparam logic [2:0] SEL_CNT  = 3'd3;
   localparam logic [2:0] SEL_CTRL = 3'd4;

   typedef enum logic [1:0] {
      XF_IDLE  = 2'd0,
      XF_READ  = 2'd1,
      XF_WRITE = 2'd2
   } xfer_state_e;

   typedef struct packed {
      logic [TRIG_SEL_W-1:0] trig_sel;
      logic                  to_per;
      logic                  wide;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
   import dma2_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 10,
   parameter int NUM_SRC = 16,
   parameter int DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NUM_SRC-1:0] trig_in,
   input  logic              grant,
   input  logic              commit,
   output logic              enable,
   output logic              live,
   output logic              pending,
   output mode_t             mode,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [ADDR_W-1:0] per_addr,
   output logic [ADDR_W-1:0] ram_eff,
   output logic [ADDR_W-1:0] per_eff,
   output logic [CNT_W-1:0]  count,
   output logic              done_pulse
);

   localparam int SRC_PAD = 1 << TRIG_SEL_W;

   logic [SRC_PAD-1:0] trig_pad;
   logic               ctrl_wr;
   logic               stop_req;
   logic               kick;
   logic               cfg_open;
   logic               trig_hit;
   logic               last_unit;
   logic               finish;
   logic [ADDR_W-1:0]  step;

   assign trig_pad  = SRC_PAD'(trig_in);
   assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
   assign stop_req  = ctrl_wr && !wr_data[0];
   assign kick      = ctrl_wr && wr_data[0] && wr_data[1];
   assign live      = enable && !stop_req;
   assign cfg_open  = wr_en && !enable;
   assign trig_hit  = trig_pad[mode.trig_sel];
   assign last_unit = (count == '0);
   assign finish    = commit && live && last_unit;

   // word units always address an even location on both sides
   assign ram_eff = mode.wide ? {ram_addr[ADDR_W-1:1], 1'b0} : ram_addr;
   assign per_eff = mode.wide ? {per_addr[ADDR_W-1:1], 1'b0} : per_addr;
   assign step    = mode.wide ? ADDR_W'(2) : ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable     <= 1'b0;
         pending    <= 1'b0;
         mode       <= '0;
         ram_addr   <= '0;
         per_addr   <= '0;
         count      <= '0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         if (wr_en && (wr_sel == SEL_MODE)) mode <= mode_t'(wr_data[MODE_W-1:0]);
         if (cfg_open && (wr_sel == SEL_RAM)) ram_addr <= wr_data[ADDR_W-1:0];
         if (cfg_open && (wr_sel == SEL_PER)) per_addr <= wr_data[ADDR_W-1:0];
         if (cfg_open && (wr_sel == SEL_CNT)) count <= wr_data[CNT_W-1:0];
         if (ctrl_wr) enable <= wr_data[0];
         if (commit && live) begin
            ram_addr <= ram_eff + step;
            if (last_unit) begin
               enable     <= 1'b0;
               done_pulse <= 1'b1;
            end else begin
               count <= count - 1'b1;
            end
         end
         if (stop_req || finish) pending <= 1'b0;
         else pending <= (pending && !grant) || (enable && trig_hit) || kick;
      end
   end

endmodule

// File: rtl/dma2_prio_arb.sv
module dma2_prio_arb #(
   parameter int N  = 2,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   // scanning downward lets the lowest requesting index win
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/dma2_xfer.sv
module dma2_xfer
   import dma2_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int IW     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_any,
   input  logic [IW-1:0]     req_idx,
   output logic              grant,
   output logic [IW-1:0]     act_idx,
   input  logic              live,
   input  logic              wide,
   input  logic              to_per,
   input  logic [ADDR_W-1:0] ram_eff,
   input  logic [ADDR_W-1:0] per_eff,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [1:0]        bus_be,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              unit_done
);

   localparam int BYTE_W = DATA_W / 2;

   xfer_state_e       state_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] src_addr;
   logic [ADDR_W-1:0] dst_addr;
   logic [BYTE_W-1:0] byte_in;

   function automatic logic [1:0] lanes(input logic a0, input logic w);
      return w ? 2'b11 : (a0 ? 2'b10 : 2'b01);
   endfunction

   assign src_addr  = to_per ? ram_eff : per_eff;
   assign dst_addr  = to_per ? per_eff : ram_eff;
   assign byte_in   = src_addr[0] ? bus_rdata[DATA_W-1:BYTE_W] : bus_rdata[BYTE_W-1:0];
   assign grant     = (state_q == XF_IDLE) && req_any;
   assign unit_done = (state_q == XF_WRITE) && live;

   always_comb begin
      bus_addr  = '0;
      bus_rd    = 1'b0;
      bus_wr    = 1'b0;
      bus_be    = 2'b00;
      bus_wdata = '0;
      case (state_q)
         XF_READ: begin
            bus_addr = src_addr;
            bus_rd   = 1'b1;
            bus_be   = lanes(src_addr[0], wide);
         end
         XF_WRITE: begin
            if (live) begin
               bus_addr  = dst_addr;
               bus_wr    = 1'b1;
               bus_be    = lanes(dst_addr[0], wide);
               bus_wdata = data_q;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XF_IDLE;
         act_idx <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            XF_IDLE: begin
               if (req_any) begin
                  act_idx <= req_idx;
                  state_q <= XF_READ;
               end
            end
            XF_READ: begin
               data_q  <= wide ? bus_rdata : {2{byte_in}};
               state_q <= live ? XF_WRITE : XF_IDLE;
            end
            default: state_q <= XF_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
   import dma2_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 10,
   parameter int NUM_SRC = 16,
   parameter int DATA_W  = 16,
   parameter int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CH_W-1:0]    cfg_ch,
   input  logic [2:0]         cfg_sel,
   input  logic [DATA_W-1:0]  cfg_wdata,
   output logic [DATA_W-1:0]  cfg_rdata,
   input  logic [NUM_SRC-1:0] trig_in,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic               bus_rd,
   output logic               bus_wr,
   output logic [1:0]         bus_be,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0]  done_irq
);

   localparam int MAX_SRC = 1 << TRIG_SEL_W;

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must lie between 1 and %0d", MAX_SRC);
   end
   if (DATA_W != 16) begin : g_bad_data
      $error("DATA_W must be 16");
   end
   if (ADDR_W < 2 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must lie between 2 and DATA_W");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie between 1 and DATA_W");
   end
   if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_ch
      $error("NUM_CH does not fit CH_W");
   end

   logic [NUM_CH-1:0] ch_en;
   logic [NUM_CH-1:0] ch_live;
   logic [NUM_CH-1:0] ch_pend;
   logic [NUM_CH-1:0] ch_commit;
   logic [NUM_CH-1:0] ch_grant;
   mode_t             ch_mode    [NUM_CH];
   logic [ADDR_W-1:0] ch_ram     [NUM_CH];
   logic [ADDR_W-1:0] ch_per     [NUM_CH];
   logic [ADDR_W-1:0] ch_ram_eff [NUM_CH];
   logic [ADDR_W-1:0] ch_per_eff [NUM_CH];
   logic [CNT_W-1:0]  ch_cnt     [NUM_CH];

   logic            arb_any;
   logic [CH_W-1:0] arb_idx;
   logic            grant;
   logic [CH_W-1:0] act_idx;
   logic            unit_done;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      assign ch_grant[g]  = grant && (arb_idx == CH_W'(g));
      assign ch_commit[g] = unit_done && (act_idx == CH_W'(g));

      dma2_chan #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .NUM_SRC(NUM_SRC),
         .DATA_W (DATA_W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (cfg_we && (cfg_ch == CH_W'(g))),
         .wr_sel    (cfg_sel),
         .wr_data   (cfg_wdata),
         .trig_in   (trig_in),
         .grant     (ch_grant[g]),
         .commit    (ch_commit[g]),
         .enable    (ch_en[g]),
         .live      (ch_live[g]),
         .pending   (ch_pend[g]),
         .mode      (ch_mode[g]),
         .ram_addr  (ch_ram[g]),
         .per_addr  (ch_per[g]),
         .ram_eff   (ch_ram_eff[g]),
         .per_eff   (ch_per_eff[g]),
         .count     (ch_cnt[g]),
         .done_pulse(done_irq[g])
      );
   end

   dma2_prio_arb #(
      .N (NUM_CH),
      .IW(CH_W)
   ) u_arb (
      .req(ch_pend),
      .any(arb_any),
      .idx(arb_idx)
   );

   dma2_xfer #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .IW    (CH_W)
   ) u_xfer (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_any  (arb_any),
      .req_idx  (arb_idx),
      .grant    (grant),
      .act_idx  (act_idx),
      .live     (ch_live[act_idx]),
      .wide     (ch_mode[act_idx].wide),
      .to_per   (ch_mode[act_idx].to_per),
      .ram_eff  (ch_ram_eff[act_idx]),
      .per_eff  (ch_per_eff[act_idx]),
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_be   (bus_be),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .unit_done(unit_done)
   );

   always_comb begin
      case (cfg_sel)
         SEL_MODE: cfg_rdata = DATA_W'(ch_mode[cfg_ch]);
         SEL_RAM:  cfg_rdata = DATA_W'(ch_ram[cfg_ch]);
         SEL_PER:  cfg_rdata = DATA_W'(ch_per[cfg_ch]);
         SEL_CNT:  cfg_rdata = DATA_W'(ch_cnt[cfg_ch]);
         SEL_CTRL: cfg_rdata = DATA_W'({ch_pend[cfg_ch], ch_en[cfg_ch]});
         default:  cfg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dma2_checks.sv
module dma2_checks #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_a0,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [1:0]        bus_be,
   input logic [NUM_CH-1:0] done_irq,
   input logic [NUM_CH-1:0] ch_en
);

   assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

   assert_wr_after_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> $past(bus_rd));

   assert_word_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && (bus_be == 2'b11)) |-> !bus_a0);

   assert_byte_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_rd || bus_wr) && (bus_be != 2'b11)) |-> ($onehot(bus_be) && (bus_be[1] == bus_a0)));

   assert_idle_no_lanes_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |-> (bus_be == 2'b00));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
         done_irq[i] |=> !done_irq[i]);

      assert_done_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
         done_irq[i] |-> !ch_en[i]);

      assert_done_after_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
         done_irq[i] |-> $past(bus_wr));
   end

endmodule

bind dma2ch_engine dma2_checks #(
   .NUM_CH(NUM_CH)
) u_checks (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_a0  (bus_addr[0]),
   .bus_rd  (bus_rd),
   .bus_wr  (bus_wr),
   .bus_be  (bus_be),
   .done_irq(done_irq),
   .ch_en   (ch_en)
);

// File: tb/tb_dma2ch_engine.sv
module tb_dma2ch_engine;
   import dma2_pkg::*;

   localparam int NUM_CH  = 2;
   localparam int ADDR_W  = 16;
   localparam int CNT_W   = 10;
   localparam int NUM_SRC = 16;
   localparam int DW      = 16;
   localparam int CH_W    = 1;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_we;
   logic [CH_W-1:0]    cfg_ch;
   logic [2:0]         cfg_sel;
   logic [DW-1:0]      cfg_wdata;
   logic [DW-1:0]      cfg_rdata;
   logic [NUM_SRC-1:0] trig_in;
   logic [ADDR_W-1:0]  bus_addr;
   logic               bus_rd;
   logic               bus_wr;
   logic [1:0]         bus_be;
   logic [DW-1:0]      bus_wdata;
   logic [DW-1:0]      bus_rdata;
   logic [NUM_CH-1:0]  done_irq;

   always #5 clk = ~clk;

   dma2ch_engine #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .NUM_SRC(NUM_SRC),
      .DATA_W (DW),
      .CH_W   (CH_W)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_ch   (cfg_ch),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .trig_in  (trig_in),
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .bus_be   (bus_be),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .done_irq (done_irq)
   );

   // memory model: every byte holds a value computed from its address
   function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
      logic [15:0] v;
      v = 16'(a[9:0]) * 16'd13 + 16'd5;
      return v[7:0];
   endfunction

   assign bus_rdata = {pat({bus_addr[ADDR_W-1:1], 1'b1}), pat({bus_addr[ADDR_W-1:1], 1'b0})};

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [1:0]        be;
      logic [DW-1:0]     data;
      logic [3:0]        req;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   done_seen[NUM_CH];
   bit   finished = 1'b0;

   // monitor: pops one expected write per observed bus write
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (bus_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R12 unexpected write actual addr=%h data=%h expected none",
                        bus_addr, bus_wdata);
            end else begin
               e = exp_q.pop_front();
               if (bus_addr !== e.addr || bus_be !== e.be || bus_wdata !== e.data) begin
                  errors++;
                  $display("FAIL R%0d write actual addr=%h be=%b data=%h expected addr=%h be=%b data=%h",
                           e.req, bus_addr, bus_be, bus_wdata, e.addr, e.be, e.data);
               end
            end
         end
         for (int i = 0; i < NUM_CH; i++) if (done_irq[i]) done_seen[i]++;
      end
   end

   // driver side of the scoreboard: expected writes of a run
   task automatic expect_run(input logic to_per, input logic wide,
                             input logic [ADDR_W-1:0] ram, input logic [ADDR_W-1:0] per,
                             input int units, input logic [3:0] req);
      logic [ADDR_W-1:0] r;
      logic [ADDR_W-1:0] p;
      logic [ADDR_W-1:0] a;
      logic [ADDR_W-1:0] s;
      exp_t e;
      r = wide ? {ram[ADDR_W-1:1], 1'b0} : ram;
      p = wide ? {per[ADDR_W-1:1], 1'b0} : per;
      for (int k = 0; k < units; k++) begin
         a = to_per ? p : r;
         s = to_per ? r : p;
         e.addr = a;
         e.req  = req;
         if (wide) begin
            e.be   = 2'b11;
            e.data = {pat(s | ADDR_W'(1)), pat(s)};
         end else begin
            e.be   = a[0] ? 2'b10 : 2'b01;
            e.data = {pat(s), pat(s)};
         end
         exp_q.push_back(e);
         r = r + (wide ? ADDR_W'(2) : ADDR_W'(1));
      end
   endtask

   task automatic check_eq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [CH_W-1:0] ch, input logic [2:0] sel, input logic [DW-1:0] d);
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
      @(posedge clk); #2;
      cfg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [CH_W-1:0] ch, input logic [2:0] sel, output logic [DW-1:0] d);
      @(posedge clk); #2;
      cfg_ch = ch; cfg_sel = sel;
      #1;
      d = cfg_rdata;
   endtask

   task automatic pulse_trig(input int idx);
      @(posedge clk); #2;
      trig_in[idx] = 1'b1;
      @(posedge clk); #2;
      trig_in = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end

   initial begin
      logic [DW-1:0] d;
      for (int i = 0; i < NUM_CH; i++) done_seen[i] = 0;
      cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0; trig_in = '0;
      repeat (3) @(posedge clk);
      #2;
      // R13: bus idle while in reset
      check_eq("R13 bus strobes in reset", DW'({bus_rd, bus_wr}), 16'h0000);
      rst_n = 1'b1;
      reg_rd(0, SEL_CTRL, d); check_eq("R13 ch0 control after reset", d, 16'h0000);
      reg_rd(1, SEL_CTRL, d); check_eq("R13 ch1 control after reset", d, 16'h0000);
      reg_rd(0, SEL_CNT, d);  check_eq("R13 ch0 count after reset", d, 16'h0000);
      check_eq("R13 done_irq after reset", DW'(done_irq), 16'h0000);

      // R1 R2 R4 R5 R7 R8: ch0 RAM to peripheral, bytes, odd peripheral lane
      reg_wr(0, SEL_MODE, 16'h0022);
      reg_wr(0, SEL_RAM,  16'h0100);
      reg_wr(0, SEL_PER,  16'h03F1);
      reg_wr(0, SEL_CNT,  16'd3);
      expect_run(1'b1, 1'b0, 16'h0100, 16'h03F1, 4, 4'd2);
      reg_wr(0, SEL_CTRL, 16'h0003);
      idle(6);
      pulse_trig(3);
      idle(6);
      reg_rd(0, SEL_CNT, d); check_eq("R7 unselected line left count", d, 16'd2);
      check_eq("R7 unselected line moved nothing", 16'(exp_q.size()), 16'd3);
      for (int k = 0; k < 3; k++) begin
         pulse_trig(8);
         idle(6);
      end
      check_eq("R5 all ch0 units written", 16'(exp_q.size()), 16'd0);
      check_eq("R5 ch0 completion pulses", 16'(done_seen[0]), 16'd1);
      reg_rd(0, SEL_CTRL, d); check_eq("R5 ch0 disabled after run", d, 16'h0000);
      reg_rd(0, SEL_CNT, d);  check_eq("R5 ch0 count at end", d, 16'h0000);
      reg_rd(0, SEL_RAM, d);  check_eq("R4 ch0 RAM pointer stepped by 1", d, 16'h0104);

      // R1 R3 R4: ch1 peripheral to RAM, words, odd RAM pointer forced even
      reg_wr(1, SEL_MODE, 16'h0009);
      reg_wr(1, SEL_RAM,  16'h0201);
      reg_wr(1, SEL_PER,  16'h03E0);
      reg_wr(1, SEL_CNT,  16'd2);
      expect_run(1'b0, 1'b1, 16'h0201, 16'h03E0, 3, 4'd3);
      reg_wr(1, SEL_CTRL, 16'h0003);
      idle(6);
      for (int k = 0; k < 2; k++) begin
         pulse_trig(2);
         idle(6);
      end
      check_eq("R1 all ch1 units written", 16'(exp_q.size()), 16'd0);
      check_eq("R5 ch1 completion pulses", 16'(done_seen[1]), 16'd1);
      reg_rd(1, SEL_RAM, d); check_eq("R4 ch1 RAM pointer stepped by 2", d, 16'h0206);
      reg_rd(1, SEL_PER, d); check_eq("R4 ch1 peripheral address fixed", d, 16'h03E0);

      // R6 R11: forced stop of ch0 after three units
      reg_wr(0, SEL_MODE, 16'h0012);
      reg_wr(0, SEL_RAM,  16'h0120);
      reg_wr(0, SEL_PER,  16'h03F2);
      reg_wr(0, SEL_CNT,  16'd9);
      expect_run(1'b1, 1'b0, 16'h0120, 16'h03F2, 3, 4'd6);
      reg_wr(0, SEL_CTRL, 16'h0003);
      idle(6);
      for (int k = 0; k < 2; k++) begin
         pulse_trig(4);
         idle(6);
      end
      reg_wr(0, SEL_CNT, 16'h0055);
      reg_wr(0, SEL_RAM, 16'h0300);
      reg_wr(0, SEL_PER, 16'h0010);
      reg_rd(0, SEL_CNT, d);  check_eq("R11 count write ignored while enabled", d, 16'd6);
      reg_rd(0, SEL_RAM, d);  check_eq("R11 RAM write ignored while enabled", d, 16'h0123);
      reg_rd(0, SEL_PER, d);  check_eq("R11 peripheral write ignored while enabled", d, 16'h03F2);
      reg_rd(0, SEL_CTRL, d); check_eq("R6 ch0 still enabled mid-run", d, 16'h0001);
      reg_wr(0, SEL_CTRL, 16'h0000);
      for (int k = 0; k < 2; k++) begin
         pulse_trig(4);
         idle(6);
      end
      reg_rd(0, SEL_CNT, d);  check_eq("R6 count frozen after stop", d, 16'd6);
      reg_rd(0, SEL_RAM, d);  check_eq("R6 RAM pointer frozen after stop", d, 16'h0123);
      reg_rd(0, SEL_CTRL, d); check_eq("R6 ch0 disabled after stop", d, 16'h0000);
      check_eq("R6 no completion pulse on stop", 16'(done_seen[0]), 16'd1);
      check_eq("R6 stopped run wrote exactly three", 16'(exp_q.size()), 16'd0);

      // R9 R10: both channels pending in the same cycle, ch0 first
      reg_wr(0, SEL_MODE, 16'h0016);
      reg_wr(0, SEL_RAM,  16'h0140);
      reg_wr(0, SEL_PER,  16'h03F4);
      reg_wr(0, SEL_CNT,  16'd0);
      reg_wr(1, SEL_MODE, 16'h0016);
      reg_wr(1, SEL_RAM,  16'h0160);
      reg_wr(1, SEL_PER,  16'h03F6);
      reg_wr(1, SEL_CNT,  16'd0);
      expect_run(1'b1, 1'b0, 16'h0140, 16'h03F4, 1, 4'd10);
      expect_run(1'b1, 1'b0, 16'h0160, 16'h03F6, 1, 4'd9);
      reg_wr(0, SEL_CTRL, 16'h0001);
      reg_wr(1, SEL_CTRL, 16'h0001);
      pulse_trig(5);
      idle(12);
      check_eq("R9 held request of ch1 served", 16'(exp_q.size()), 16'd0);
      check_eq("R10 ch0 completion", 16'(done_seen[0]), 16'd2);
      check_eq("R10 ch1 completion", 16'(done_seen[1]), 16'd2);

      // R3 R8: word RAM to odd peripheral address, software kicks only
      reg_wr(1, SEL_MODE, 16'h0003);
      reg_wr(1, SEL_RAM,  16'h0181);
      reg_wr(1, SEL_PER,  16'h03E9);
      reg_wr(1, SEL_CNT,  16'd1);
      expect_run(1'b1, 1'b1, 16'h0181, 16'h03E9, 2, 4'd3);
      reg_wr(1, SEL_CTRL, 16'h0003);
      idle(6);
      reg_wr(1, SEL_CTRL, 16'h0003);
      idle(8);
      check_eq("R8 kicks moved both words", 16'(exp_q.size()), 16'd0);
      check_eq("R8 ch1 completion after kicks", 16'(done_seen[1]), 16'd3);
      reg_rd(1, SEL_RAM, d); check_eq("R3 word pointer from even base", d, 16'h0184);

      report();
   end

endmodule